// File: doc/BRIEF.md
# Fault-Protected Bus Manager Port

This block connects a processor's fetch and load/store logic to a single-manager AHB-Lite bus. It also hardens every transfer against transient upsets on the wires. Each class of signal gets its own protection:

- Control lines that the block drives carry even parity bits.
- The subordinate's ready and response lines arrive as three copies and are resolved by bitwise majority.
- Data travels as a 39-bit SECDED codeword instead of 32 plain bits.

Each protection has its own elaboration-time enable. With an enable cleared, that part reverts to plain AHB-Lite signalling: the bus data is 32 raw bits, parity outputs are tied low, and only copy 0 of the ready and response lines is used.

The request side is a valid/ready stream. `req_ready` is the voted bus ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the requester must hold the address, size, write flag and write data stable. The address phase is driven straight from the request, so a new request may overlap the data phase of the previous transfer.

The response side has no back-pressure, because the bus cannot be paused once a data phase ends. `rsp_valid` is a single-cycle pulse that the requester must take.

Top module: `prot_bus_mgr`

## Requirements
- R1: While reset is held, and in the first cycle after it, `htrans` is IDLE (2'b00). In the same window `rsp_valid`, `ecc_corr`, `ecc_uncorr` and `vote_mismatch` are low.
- R2: Whenever `req_valid` is high, `htrans` is NONSEQ (2'b10) and `haddr`, `hsize`, `hwrite` equal the request fields. `req_ready` equals the voted ready. A request accepted on one edge may be followed by another in the very next cycle, so the two transfers overlap.
- R3: `haddr_par` is the XOR of all `haddr` bits. `hctrl_par` is the XOR of `htrans`, `hsize` and `hwrite`. Both are valid in the same cycle as the signals they cover.
- R4: The ready and response values used internally are the bitwise majority of the three copies `hready_cp` and `hresp_cp`. A single faulty copy changes neither stalling nor error reporting.
- R5: `vote_mismatch` is high for exactly the cycle after a clock edge at which the three ready copies, or the three response copies, did not all agree.
- R6: During the data phase of a write, `hwdata` carries the 39-bit code of the write data, laid out as follows:
  - bit k-1 holds Hamming position k, for k = 1..38;
  - check bits sit at positions 1, 2, 4, 8, 16 and 32;
  - data bits 0..31 fill the other positions in ascending order;
  - bit 38 makes the even parity of all 39 bits.
- R7: `rsp_valid` pulses in the cycle after the edge at which a data phase completes with voted ready high. Then `rsp_err` equals the voted response, ORed with the uncorrectable flag on reads, and for clean reads `rsp_rdata` holds the decoded data.
- R8: A read codeword with one flipped bit, in any of its 39 positions, returns the original data. `ecc_corr` pulses in the same cycle as `rsp_valid`.
- R9: A read codeword with two flipped bits pulses `ecc_uncorr` together with `rsp_valid`, and reports `rsp_err` high.
- R10: While the voted ready is low during a data phase, the transfer stays open and no response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle (voted bus ready) |
| req_addr | input | ADDR_W | Transfer address |
| req_size | input | 3 | Transfer size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Corrected read data |
| rsp_err | output | 1 | Bus error or uncorrectable data |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type (IDLE / NONSEQ) |
| hsize | output | 3 | Bus transfer size |
| hwrite | output | 1 | Bus write flag |
| haddr_par | output | 1 | Even parity of haddr |
| hctrl_par | output | 1 | Even parity of htrans, hsize, hwrite |
| hwdata | output | BUS_W | Encoded write data |
| hrdata | input | BUS_W | Encoded read data |
| hready_cp | input | 3 | Three copies of subordinate ready |
| hresp_cp | input | 3 | Three copies of subordinate response |
| ecc_corr | output | 1 | Single-bit read error corrected |
| ecc_uncorr | output | 1 | Double-bit read error detected |
| vote_mismatch | output | 1 | Redundant copies disagreed |

## Verification
The hardest situation to reach is a one-copy fault that lands exactly on the completing edge of a data phase, or during its wait states. One such fault would otherwise end a stall too early; another would turn a clean transfer into an error. The stimulus reaches these cases by holding the ready copies in patterns such as 101 and 001 while a data phase is open, and by flipping a single response copy on the completing edge. Read data is built as the independently encoded word XORed with a chosen mask. That mask flips data, check and overall-parity positions one at a time, and also flips pairs of bits. Two requests are also issued back to back, with the address of the second on the bus while the first is still stalled.

// File: rtl/prot_bus_pkg.sv
package prot_bus_pkg;
  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_NONSEQ = 2'b10
  } trans_e;

  // number of Hamming check bits for a given data width
  function automatic int ecc_chk(int dw);
    int p;
    p = 0;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction
endpackage

// File: rtl/prot_bus_ecc_enc.sv
module prot_bus_ecc_enc #(
  parameter int DATA_W = 32,
  localparam int HP   = prot_bus_pkg::ecc_chk(DATA_W),
  localparam int NPOS = DATA_W + HP,
  localparam int CW   = NPOS + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CW-1:0]     code
);
  always_comb begin
    logic [CW-1:0] c;
    logic          par;
    int            di;
    c  = '0;
    di = 0;
    for (int pos = 1; pos <= NPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        c[pos-1] = data[di];
        di++;
      end
    end
    for (int p = 0; p < HP; p++) begin
      par = 1'b0;
      for (int pos = 1; pos <= NPOS; pos++)
        if (((pos >> p) & 1) != 0) par = par ^ c[pos-1];
      c[(1 << p) - 1] = par;
    end
    c[CW-1] = ^c[CW-2:0];
    code = c;
  end
endmodule

// File: rtl/prot_bus_ecc_dec.sv
module prot_bus_ecc_dec #(
  parameter int DATA_W = 32,
  localparam int HP   = prot_bus_pkg::ecc_chk(DATA_W),
  localparam int NPOS = DATA_W + HP,
  localparam int CW   = NPOS + 1
) (
  input  logic [CW-1:0]     code,
  output logic [DATA_W-1:0] data,
  output logic              corr,
  output logic              uncorr
);
  always_comb begin
    logic [HP-1:0] syn;
    logic [CW-1:0] fixed;
    logic          ovr;
    int            di;
    syn = '0;
    for (int pos = 1; pos <= NPOS; pos++)
      for (int p = 0; p < HP; p++)
        if (((pos >> p) & 1) != 0) syn[p] = syn[p] ^ code[pos-1];
    ovr   = ^code;
    fixed = code;
    for (int pos = 1; pos <= NPOS; pos++)
      if (ovr && int'(syn) == pos) fixed[pos-1] = ~fixed[pos-1];
    corr   = ovr && (int'(syn) <= NPOS);
    uncorr = (!ovr && syn != '0) || (ovr && int'(syn) > NPOS);
    data = '0;
    di   = 0;
    for (int pos = 1; pos <= NPOS; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        data[di] = fixed[pos-1];
        di++;
      end
    end
  end
endmodule

// File: rtl/prot_bus_vote.sv
module prot_bus_vote #(
  parameter bit EN = 1'b1
) (
  input  logic [2:0] cp,
  output logic       val,
  output logic       mis
);
  generate
    if (EN) begin : g_tmr
      assign val = (cp[0] & cp[1]) | (cp[0] & cp[2]) | (cp[1] & cp[2]);
      assign mis = !((cp == 3'b000) || (cp == 3'b111));
    end else begin : g_plain
      assign val = cp[0];
      assign mis = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/prot_bus_mgr.sv
module prot_bus_mgr #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter bit PAR_EN = 1'b1,
  parameter bit ECC_EN = 1'b1,
  parameter bit TMR_EN = 1'b1,
  localparam int BUS_W = ECC_EN ? DATA_W + prot_bus_pkg::ecc_chk(DATA_W) + 1 : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hsize,
  output logic              hwrite,
  output logic              haddr_par,
  output logic              hctrl_par,
  output logic [BUS_W-1:0]  hwdata,
  input  logic [BUS_W-1:0]  hrdata,
  input  logic [2:0]        hready_cp,
  input  logic [2:0]        hresp_cp,
  output logic              ecc_corr,
  output logic              ecc_uncorr,
  output logic              vote_mismatch
);
  import prot_bus_pkg::*;

  logic              rdy_v, resp_v, mis_rdy, mis_resp;
  logic              dp_valid, dp_write;
  logic [BUS_W-1:0]  dp_wcode, wcode;
  logic [DATA_W-1:0] rd_data;
  logic              rd_corr, rd_uncorr, done;

  prot_bus_vote #(.EN(TMR_EN)) u_vote_rdy  (.cp(hready_cp), .val(rdy_v),  .mis(mis_rdy));
  prot_bus_vote #(.EN(TMR_EN)) u_vote_resp (.cp(hresp_cp),  .val(resp_v), .mis(mis_resp));

  // address phase driven straight from the request stream
  assign htrans    = req_valid ? TR_NONSEQ : TR_IDLE;
  assign haddr     = req_addr;
  assign hsize     = req_size;
  assign hwrite    = req_write;
  assign req_ready = rdy_v;

  generate
    if (PAR_EN) begin : g_par
      assign haddr_par = ^haddr;
      assign hctrl_par = ^{htrans, hsize, hwrite};
    end else begin : g_nopar
      assign haddr_par = 1'b0;
      assign hctrl_par = 1'b0;
    end

    if (ECC_EN) begin : g_ecc
      prot_bus_ecc_enc #(.DATA_W(DATA_W)) u_enc (.data(req_wdata), .code(wcode));
      prot_bus_ecc_dec #(.DATA_W(DATA_W)) u_dec (
        .code(hrdata), .data(rd_data), .corr(rd_corr), .uncorr(rd_uncorr));
    end else begin : g_noecc
      assign wcode     = req_wdata;
      assign rd_data   = hrdata;
      assign rd_corr   = 1'b0;
      assign rd_uncorr = 1'b0;
    end
  endgenerate

  assign done   = dp_valid && rdy_v;
  assign hwdata = dp_wcode;

  // data phase tracking: advances only on voted ready
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_wcode <= '0;
    end else if (rdy_v) begin
      dp_valid <= req_valid;
      dp_write <= req_write;
      dp_wcode <= wcode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_err       <= 1'b0;
      ecc_corr      <= 1'b0;
      ecc_uncorr    <= 1'b0;
      vote_mismatch <= 1'b0;
    end else begin
      rsp_valid     <= done;
      rsp_rdata     <= rd_data;
      rsp_err       <= done && (resp_v || (!dp_write && rd_uncorr));
      ecc_corr      <= done && !dp_write && rd_corr;
      ecc_uncorr    <= done && !dp_write && rd_uncorr;
      vote_mismatch <= mis_rdy || mis_resp;
    end
  end

  // R7
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(dp_valid && rdy_v));

  // R10
  stall_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !rdy_v) |=> !rsp_valid);

  // R9
  uncorr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_uncorr |-> (rsp_err && rsp_valid));

  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ecc_corr && ecc_uncorr));

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_valid && !rdy_v) |=> $stable(dp_wcode));
endmodule

// File: tb/tb_prot_bus_mgr.sv
module tb_prot_bus_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0]  req_size = 3'd2;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata, haddr;
  logic [1:0]  htrans;
  logic [2:0]  hsize;
  logic        hwrite, haddr_par, hctrl_par, ecc_corr, ecc_uncorr, vote_mismatch;
  logic [38:0] hwdata, hrdata, flipmask = '0;
  logic [2:0]  hready_c = 3'b111, hresp_c = 3'b000;
  logic [31:0] rd_val = '0;
  int          nflip = 0;
  int          nchk = 0, nerr = 0, cyc = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  function automatic logic [38:0] b_enc(logic [31:0] d);
    logic [38:0] w;
    int k, acc;
    w = '0; k = 0; acc = 0;
    for (int pos = 1; pos <= 38; pos++) begin
      if (pos == 1 || pos == 2 || pos == 4 || pos == 8 || pos == 16 || pos == 32) continue;
      w[pos-1] = d[k];
      if (d[k]) acc = acc ^ pos;
      k++;
    end
    for (int p = 0; p < 6; p++) w[(1 << p) - 1] = acc[p];
    w[38] = ^w[37:0];
    return w;
  endfunction

  function automatic logic maj3(logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  assign hrdata = b_enc(rd_val) ^ flipmask;

  prot_bus_mgr dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .haddr(haddr), .htrans(htrans), .hsize(hsize), .hwrite(hwrite),
    .haddr_par(haddr_par), .hctrl_par(hctrl_par), .hwdata(hwdata), .hrdata(hrdata),
    .hready_cp(hready_c), .hresp_cp(hresp_c),
    .ecc_corr(ecc_corr), .ecc_uncorr(ecc_uncorr), .vote_mismatch(vote_mismatch));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on each rising edge
  bit          m_dp = 0, m_dw = 0, m_ev = 0, m_wr = 0, m_err = 0;
  bit          m_corr = 0, m_unc = 0, m_mis = 0, m_stall = 0;
  logic [31:0] m_dd = '0, m_rd = '0;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_dp = 0; m_ev = 0; m_corr = 0; m_unc = 0; m_mis = 0; m_stall = 0;
    end else begin
      logic vr, ve;
      vr = maj3(hready_c);
      ve = maj3(hresp_c);
      m_ev = 0; m_corr = 0; m_unc = 0;
      m_stall = m_dp && !vr;
      m_mis = !(hready_c == 3'b000 || hready_c == 3'b111) ||
              !(hresp_c == 3'b000 || hresp_c == 3'b111);
      if (m_dp && vr) begin
        m_ev = 1; m_wr = m_dw; m_rd = rd_val;
        if (!m_dw) begin m_corr = (nflip == 1); m_unc = (nflip == 2); end
        m_err = ve || m_unc;
        m_dp = 0;
      end
      if (vr) begin m_dp = req_valid; m_dw = req_write; m_dd = req_wdata; end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 htrans", htrans, req_valid ? 2'b10 : 2'b00);
      if (req_valid) chk("R2 haddr", haddr, req_addr);
      if (req_valid) chk("R2 hwrite", hwrite, req_write);
      chk("R4 req_ready vote", req_ready, maj3(hready_c));
      chk("R3 haddr_par", haddr_par, ^haddr);
      chk("R3 hctrl_par", hctrl_par, ^{htrans, hsize, hwrite});
      if (m_dp && m_dw) chk("R6 hwdata code", hwdata, b_enc(m_dd));
      chk("R7 rsp_valid", rsp_valid, m_ev);
      if (m_stall) chk("R10 no response while stalled", rsp_valid, 1'b0);
      if (m_ev) chk("R7 rsp_err", rsp_err, m_err);
      if (m_ev && !m_wr && nflip < 2) chk("R8 rsp_rdata", rsp_rdata, m_rd);
      chk("R8 ecc_corr", ecc_corr, m_corr);
      chk("R9 ecc_uncorr", ecc_uncorr, m_unc);
      chk("R5 vote_mismatch", vote_mismatch, m_mis);
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic step(input logic [2:0] r, input logic [2:0] e);
    hready_c = r; hresp_c = e;
    @(posedge clk); #2;
  endtask

  task automatic issue(input logic w, input logic [31:0] a, input logic [31:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
  endtask

  task automatic idle();
    req_valid = 0;
  endtask

  task automatic set_read(input logic [31:0] v, input logic [38:0] m, input int n);
    rd_val = v; flipmask = m; nflip = n;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    @(negedge clk);
    // R1 reset state
    chk("R1 htrans", htrans, 2'b00);
    chk("R1 rsp_valid", rsp_valid, 1'b0);
    chk("R1 flags", {ecc_corr, ecc_uncorr, vote_mismatch}, 3'b000);
    @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {rsp_valid, ecc_corr, ecc_uncorr, vote_mismatch}, 4'b0);
    @(posedge clk); #2;

    // plain write
    issue(1, 32'h0000_1000, 32'hDEAD_BEEF); step(3'b111, 3'b000);
    idle(); step(3'b111, 3'b000); step(3'b111, 3'b000);
    // clean read
    set_read(32'h1234_5678, '0, 0);
    issue(0, 32'h0000_2004, '0); step(3'b111, 3'b000);
    idle(); step(3'b111, 3'b000); step(3'b111, 3'b000);
    // R10 read with two wait states
    set_read(32'hCAFE_0001, '0, 0);
    issue(0, 32'h0000_3008, '0); step(3'b111, 3'b000);
    idle(); step(3'b000, 3'b000); step(3'b000, 3'b000); step(3'b111, 3'b000);
    step(3'b111, 3'b000);
    // R8 single flips: data bit, overall parity bit, check bit
    foreach (flipmask[i]) begin end
    for (int k = 0; k < 3; k++) begin
      set_read(32'hA5A5_0F0F + k, 39'd1 << ((k == 0) ? 5 : (k == 1) ? 38 : 0), 1);
      issue(0, 32'h0000_4000 + 4 * k, '0); step(3'b111, 3'b000);
      idle(); step(3'b111, 3'b000); step(3'b111, 3'b000);
    end
    // R9 double flip
    set_read(32'h0BAD_F00D, (39'd1 << 3) | (39'd1 << 20), 2);
    issue(0, 32'h0000_5000, '0); step(3'b111, 3'b000);
    idle(); step(3'b111, 3'b000); step(3'b111, 3'b000);
    set_read(32'h0, '0, 0);
    // R7 bus error on write, all copies agree
    issue(1, 32'h0000_6000, 32'h5555_AAAA); step(3'b111, 3'b000);
    idle(); step(3'b111, 3'b111); step(3'b111, 3'b000);
    // R4 R5 one ready copy low on completing edge
    set_read(32'h7777_1111, '0, 0);
    issue(0, 32'h0000_7000, '0); step(3'b111, 3'b000);
    idle(); step(3'b101, 3'b000); step(3'b111, 3'b000);
    // R4 R5 one response copy high on completing edge
    issue(1, 32'h0000_7100, 32'h0102_0304); step(3'b111, 3'b000);
    idle(); step(3'b111, 3'b010); step(3'b111, 3'b000);
    // R4 R10 one ready copy high during a stall
    set_read(32'h4242_4242, '0, 0);
    issue(0, 32'h0000_7200, '0); step(3'b111, 3'b000);
    idle(); step(3'b001, 3'b000); step(3'b111, 3'b000); step(3'b111, 3'b000);
    // R2 back-to-back overlapped transfers
    set_read(32'h9999_0000, '0, 0);
    issue(0, 32'h0000_8000, '0); step(3'b111, 3'b000);
    issue(1, 32'h0000_8004, 32'hFEED_F00D); step(3'b111, 3'b000);
    idle(); step(3'b111, 3'b000); step(3'b111, 3'b000);
    // R2 R10 second request held while first data phase stalls
    set_read(32'h3141_5926, '0, 0);
    issue(0, 32'h0000_9000, '0); step(3'b111, 3'b000);
    issue(1, 32'h0000_9004, 32'h2718_2818); step(3'b000, 3'b000);
    step(3'b000, 3'b000); step(3'b111, 3'b000);
    idle(); step(3'b111, 3'b000); step(3'b111, 3'b000);
    repeat (3) step(3'b111, 3'b000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule